// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This peripheral guards a system against software that has stopped running. The system clock paces it, and a one-cycle enable pulse stands for each edge of a 32.768 kHz slow clock. The block divides those pulses down to a 256 Hz tick, which steps a 12-bit down-counter. Software keeps the counter from reaching the end by writing a restart command to the control register. That write takes effect only when it carries the correct 8-bit key in its top byte. When the counter runs past zero, the block raises a fault interrupt, a reset request, or both. Which one it raises depends on the mode register.

A restart that comes too early also counts as a fault. Too early means the counter still holds more than the window value. After every accepted restart or mode write, control and mode writes are refused for three slow-clock pulses. A refused write is recorded in a status flag. While the watchdog is disabled, the reload and window fields cannot be changed. Two halt inputs, one for idle and one for debug, can each freeze the counter when their mode bit is set.

Top module: `wdt_window_guard`

## Requirements
- R1: After reset the mode register reads 0x0FFF_2FFF. This means reload 4095 in bits [11:0] and window 4095 in bits [27:16]. The reset-enable bit 13 is 1. The fault-enable bit 12, idle-halt bit 14, debug-halt bit 15 and disable bit 31 are all 0. The count is 4095, the status reads 0 and the watchdog runs.
- R2: While enabled and not halted, the count drops by one every PRESC_DIV slow-clock pulses, and it does not move without pulses. A tick at count 0 reloads the reload value and sets status bit 0 (underflow).
- R3: A write to address 0 restarts the counter only when bits [31:24] equal KEY (0x5A) and bit 0 is 1 in that same write. Any other control write has no effect.
- R4: For LOCK_SLOW slow-clock pulses after an accepted restart or mode write, writes to address 0 or 1 are ignored, and status bit 2 (blocked write) is set.
- R5: A mode write leaves reload and window unchanged when the current disable bit is set or when the write itself sets bit 31. Its other bits still take effect. While disabled, the counter does not count.
- R6: An accepted mode write (address 1) reloads the counter with the resulting reload value.
- R7: An accepted keyed restart while enabled and with the count above the window value sets status bit 1 (window error). The counter is still reloaded. A restart at or below the window value sets no error.
- R8: fault_irq equals fault-enable AND (underflow OR window error). rst_req equals reset-enable AND (underflow OR window error).
- R9: With idle-halt set and idle_i high, the count is frozen. With debug-halt set and dbg_i high, the count is frozen.
- R10: Reading address 2 returns {blocked, window error, underflow} in bits [2:0] and clears those three flags. A flag raised in the same cycle as the read is kept.
- R11: rd_data is registered one cycle after rd_en. Address 1 returns the mode word and address 3 returns the count in bits [11:0]. Address 0, or rd_en low, gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_en | input | 1 | One pulse per slow-clock edge |
| idle_i | input | 1 | System idle indication |
| dbg_i | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Registered read data |
| fault_irq | output | 1 | Fault interrupt |
| rst_req | output | 1 | Reset request |

## Verification
The counter is driven with several slow-clock pulse patterns: every cycle, two in three, and none. This tells the prescaler ratio apart from plain cycle counting and shows that the counter rests without pulses.

Restarts are issued in several forms: with the right key, with a wrong key, with a missing restart bit, above the window, below the window, and inside the lockout. Each one gives a different status signature.

Mode writes are made while enabled, while disabled and while setting disable, which separates the field freeze from the flag update. The halt inputs are raised with and without their mode bits. A behavioural model checks every read word and output on each cycle.

// File: rtl/wdt_pkg.sv
// Shared constants for the windowed watchdog: register addresses,
// field positions inside the mode, control and status words, and the
// type holding the single-bit mode options.
package wdt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

    // control word fields
    localparam int CB_RESTART = 0;
    localparam int CB_KEY_LO  = 24;

    // mode word fields
    localparam int MB_FLT_EN  = 12;
    localparam int MB_RST_EN  = 13;
    localparam int MB_IDLE    = 14;
    localparam int MB_DBG     = 15;
    localparam int MB_WIN_LO  = 16;
    localparam int MB_DIS     = 31;

    // status word fields
    localparam int SB_UF  = 0;
    localparam int SB_WE  = 1;
    localparam int SB_BLK = 2;

    typedef struct packed {
        logic dis;
        logic dbg_halt;
        logic idle_halt;
        logic rst_en;
        logic flt_en;
    } mode_flags_t;

endpackage

// File: rtl/wdt_tick_gen.sv
// Prescaler: counts slow-clock enable pulses and produces a one-cycle
// tick on every DIV-th pulse. Assumes DIV >= 2. Free running; it is not
// reset by restarts.
module wdt_tick_gen #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;

    assign tick = slow_en && (pcnt == LAST);

    // advance the prescale count on each slow pulse, wrapping at DIV
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (slow_en)
            pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/wdt_lockout.sv
// Post-restart lockout: arm loads SLOW, and each slow pulse decrements
// the count until it reaches zero. busy is high while the count is
// non-zero. Assumes SLOW >= 1.
module wdt_lockout #(
    parameter int SLOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    input  logic arm,
    output logic busy
);
    localparam int LW = $clog2(SLOW + 1);
    localparam logic [LW-1:0] LOAD = LW'(SLOW);

    logic [LW-1:0] lcnt;

    assign busy = (lcnt != '0);

    // reload on arm, otherwise count slow pulses down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            lcnt <= '0;
        else if (arm)
            lcnt <= LOAD;
        else if (slow_en && busy)
            lcnt <= lcnt - 1'b1;
    end
endmodule

// File: rtl/wdt_down_counter.sv
// Timeout counter: load has priority over step. A step at zero wraps
// to wrap_val and flags wrap for that cycle.
module wdt_down_counter #(
    parameter int W = 12,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = step && !load && (cnt == '0);

    // load, decrement or wrap the count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (step)
            cnt <= (cnt == '0) ? wrap_val : cnt - 1'b1;
    end
endmodule

// File: rtl/wdt_window_guard.sv
// Key-protected windowed watchdog, top level.
// Register port: single cycle. Writes act on the clock edge where
// wr_en is high. Reads return data one cycle after rd_en.
// Assumes CNT_W <= 12 so that reload and window fit their mode fields.
// slow_en must be a one-cycle pulse per slow-clock edge.
module wdt_window_guard
    import wdt_pkg::*;
#(
    parameter int          CNT_W     = 12,
    parameter int          PRESC_DIV = 128,
    parameter int          LOCK_SLOW = 3,
    parameter logic [7:0]  KEY       = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic              idle_i,
    input  logic              dbg_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              fault_irq,
    output logic              rst_req
);
    localparam logic [CNT_W-1:0] MAX_VAL = '1;
    localparam mode_flags_t FLAGS_RST = '{dis: 1'b0, dbg_halt: 1'b0,
                                          idle_halt: 1'b0, rst_en: 1'b1,
                                          flt_en: 1'b0};

    logic [CNT_W-1:0]  reload_q, window_q, reload_nx, window_nx, cnt_q;
    mode_flags_t       flags_q;
    logic              uf_q, we_q, blk_q;
    logic [DATA_W-1:0] rd_q, rd_word;
    logic              tick, lock_busy, wrap;
    logic              wr_ctrl, wr_mode, key_ok, restart_ok, mode_ok;
    logic              blocked_wr, win_viol, freeze_fields, load_evt;
    logic              halted, step, stat_rd;

    // write decode and acceptance
    assign wr_ctrl    = wr_en && (addr == A_CTRL);
    assign wr_mode    = wr_en && (addr == A_MODE);
    assign blocked_wr = (wr_ctrl || wr_mode) && lock_busy;
    assign key_ok     = (wr_data[CB_KEY_LO +: 8] == KEY) && wr_data[CB_RESTART];
    assign restart_ok = wr_ctrl && !lock_busy && key_ok;
    assign mode_ok    = wr_mode && !lock_busy;
    assign load_evt   = restart_ok || mode_ok;
    assign win_viol   = restart_ok && !flags_q.dis && (cnt_q > window_q);

    // reload and window stay put while disabled or when being disabled
    assign freeze_fields = flags_q.dis || wr_data[MB_DIS];
    assign reload_nx = (mode_ok && !freeze_fields) ? wr_data[CNT_W-1:0] : reload_q;
    assign window_nx = (mode_ok && !freeze_fields) ? wr_data[MB_WIN_LO +: CNT_W] : window_q;

    // counting enable
    assign halted  = (flags_q.idle_halt && idle_i) || (flags_q.dbg_halt && dbg_i);
    assign step    = tick && !flags_q.dis && !halted;
    assign stat_rd = rd_en && (addr == A_STAT);

    wdt_tick_gen #(.DIV(PRESC_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .tick(tick)
    );

    wdt_lockout #(.SLOW(LOCK_SLOW)) u_lock (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .arm(load_evt),
        .busy(lock_busy)
    );

    wdt_down_counter #(.W(CNT_W), .RST_VAL(MAX_VAL)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_evt), .load_val(reload_nx),
        .step(step), .wrap_val(reload_q), .cnt(cnt_q), .wrap(wrap)
    );

    // mode register update on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= MAX_VAL;
            window_q <= MAX_VAL;
            flags_q  <= FLAGS_RST;
        end else if (mode_ok) begin
            reload_q          <= reload_nx;
            window_q          <= window_nx;
            flags_q.dis       <= wr_data[MB_DIS];
            flags_q.dbg_halt  <= wr_data[MB_DBG];
            flags_q.idle_halt <= wr_data[MB_IDLE];
            flags_q.rst_en    <= wr_data[MB_RST_EN];
            flags_q.flt_en    <= wr_data[MB_FLT_EN];
        end
    end

    // status flags: set by events, cleared by a status read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q  <= 1'b0;
            we_q  <= 1'b0;
            blk_q <= 1'b0;
        end else begin
            uf_q  <= (uf_q  && !stat_rd) || wrap;
            we_q  <= (we_q  && !stat_rd) || win_viol;
            blk_q <= (blk_q && !stat_rd) || blocked_wr;
        end
    end

    // read word selection
    always_comb begin
        rd_word = '0;
        case (addr)
            A_MODE: begin
                rd_word[CNT_W-1:0]          = reload_q;
                rd_word[MB_FLT_EN]          = flags_q.flt_en;
                rd_word[MB_RST_EN]          = flags_q.rst_en;
                rd_word[MB_IDLE]            = flags_q.idle_halt;
                rd_word[MB_DBG]             = flags_q.dbg_halt;
                rd_word[MB_WIN_LO +: CNT_W] = window_q;
                rd_word[MB_DIS]             = flags_q.dis;
            end
            A_STAT: begin
                rd_word[SB_UF]  = uf_q;
                rd_word[SB_WE]  = we_q;
                rd_word[SB_BLK] = blk_q;
            end
            A_CNT:   rd_word[CNT_W-1:0] = cnt_q;
            default: rd_word = '0;
        endcase
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_en ? rd_word : '0;
    end

    assign rd_data   = rd_q;
    assign fault_irq = flags_q.flt_en && (uf_q || we_q);
    assign rst_req   = flags_q.rst_en && (uf_q || we_q);

endmodule

// File: rtl/wdt_window_guard_chk.sv
// Property checker for wdt_window_guard, attached with bind.
module wdt_window_guard_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_i,
    input logic             dbg_i,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic             tick,
    input logic             load_evt,
    input logic             lock_busy,
    input logic             dis,
    input logic             idle_halt,
    input logic             dbg_halt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] window,
    input logic             uf,
    input logic             blk
);
    // R5
    frozen_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> ($stable(reload) && $stable(window)));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && !load_evt) |=> $stable(cnt));

    // R9
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_halt && idle_i && !load_evt) |=> $stable(cnt));

    // R9
    dbg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && dbg_i && !load_evt) |=> $stable(cnt));

    // R4
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_busy && wr_en && (addr <= 2'd1)) |=> blk);

    // R2
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_evt && (cnt != '0)) |=> (cnt <= $past(cnt)));

    // R2
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dis && !(idle_halt && idle_i) && !(dbg_halt && dbg_i)
         && !load_evt && (cnt == '0)) |=> uf);
endmodule

bind wdt_window_guard wdt_window_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .dbg_i(dbg_i),
    .wr_en(wr_en), .addr(addr), .tick(tick), .load_evt(load_evt),
    .lock_busy(lock_busy), .dis(flags_q.dis), .idle_halt(flags_q.idle_halt),
    .dbg_halt(flags_q.dbg_halt), .cnt(cnt_q), .reload(reload_q),
    .window(window_q), .uf(uf_q), .blk(blk_q)
);

// File: tb/wdt_window_guard_test.sv
// Bench: directed scenarios plus a behavioural model compared each cycle.
module wdt_window_guard_test;
    localparam int DIV  = 4;
    localparam int LOCK = 3;
    localparam logic [7:0] KEY = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic        idle_i = 1'b0, dbg_i = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        fault_irq, rst_req;

    int n_chk = 0, n_fail = 0, cyc = 0, slow_sel = 1;
    bit done = 1'b0;

    wdt_window_guard #(.CNT_W(12), .PRESC_DIV(DIV), .LOCK_SLOW(LOCK), .KEY(KEY)) uut (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .idle_i(idle_i),
        .dbg_i(dbg_i), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .fault_irq(fault_irq), .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // slow pulse pattern: 0 every cycle, 1 two of three, 2 none
    always @(negedge clk) begin
        cyc++;
        case (slow_sel)
            0: slow_en <= 1'b1;
            1: slow_en <= (cyc % 3) != 2;
            default: slow_en <= 1'b0;
        endcase
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            finish_run();
        end
    end

    // behavioural reference model
    int m_rel, m_win, m_cnt, m_pc, m_lock;
    bit m_dis, m_fen, m_ren, m_ih, m_dh, m_uf, m_we, m_blk;
    logic [31:0] m_rd;

    always @(posedge clk) begin
        bit tick, ld, halt, s_uf, s_we, s_blk, old_dis;
        int ldv;
        logic [31:0] rdv;
        if (!rst_n) begin
            m_rel = 4095; m_win = 4095; m_cnt = 4095; m_pc = 0; m_lock = 0;
            m_dis = 0; m_fen = 0; m_ren = 1; m_ih = 0; m_dh = 0;
            m_uf = 0; m_we = 0; m_blk = 0; m_rd = '0;
        end else begin
            tick = slow_en && (m_pc == DIV - 1);
            if (slow_en) m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
            rdv = '0;
            if (rd_en) begin
                if (addr == 2'd1)
                    rdv = {m_dis, 3'b0, 12'(m_win), m_dh, m_ih, m_ren, m_fen, 12'(m_rel)};
                else if (addr == 2'd2) rdv = {29'b0, m_blk, m_we, m_uf};
                else if (addr == 2'd3) rdv = 32'(m_cnt);
            end
            halt = (m_ih && idle_i) || (m_dh && dbg_i);
            old_dis = m_dis;
            ld = 0; s_uf = 0; s_we = 0; s_blk = 0; ldv = m_rel;
            if (wr_en && addr <= 2'd1) begin
                if (m_lock != 0) s_blk = 1;
                else if (addr == 2'd0) begin
                    if (wr_data[31:24] == KEY && wr_data[0]) begin
                        ld = 1;
                        if (!m_dis && m_cnt > m_win) s_we = 1;
                    end
                end else begin
                    if (!m_dis && !wr_data[31]) begin
                        m_rel = int'(wr_data[11:0]);
                        m_win = int'(wr_data[27:16]);
                    end
                    m_dis = wr_data[31]; m_fen = wr_data[12]; m_ren = wr_data[13];
                    m_ih = wr_data[14]; m_dh = wr_data[15];
                    ld = 1; ldv = m_rel;
                end
            end
            if (ld) m_cnt = ldv;
            else if (tick && !old_dis && !halt) begin
                if (m_cnt == 0) begin m_cnt = m_rel; s_uf = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (ld) m_lock = LOCK;
            else if (slow_en && m_lock != 0) m_lock = m_lock - 1;
            if (rd_en && addr == 2'd2) begin m_uf = 0; m_we = 0; m_blk = 0; end
            m_uf = m_uf | s_uf; m_we = m_we | s_we; m_blk = m_blk | s_blk;
            m_rd = rdv;
        end
    end

    // cycle compare against the model (R2 R8 R10 R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11 read word vs model", rd_data, m_rd);
            chk("R8 fault_irq vs model", {31'b0, fault_irq}, {31'b0, m_fen && (m_uf || m_we)});
            chk("R8 rst_req vs model", {31'b0, rst_req}, {31'b0, m_ren && (m_uf || m_we)});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, a, b;
        idle(4);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd1, v); chk("R1 mode after reset", v, 32'h0FFF_2FFF);
        rd(2'd2, v); chk("R1 status after reset", v, 32'h0);
        rd(2'd3, v); chk("R1 count near max", {31'b0, v >= 32'd4094}, 32'd1);
        chk("R1 no outputs", {30'b0, fault_irq, rst_req}, 32'h0);

        // R6 R7 early restart triggers window error
        wr(2'd1, 32'h000A_1014);
        idle(10);
        wr(2'd0, {KEY, 24'h000001});
        // R4 write inside lockout is blocked
        wr(2'd1, 32'h0000_2005);
        chk("R7 fault_irq on window error", {31'b0, fault_irq}, 32'd1);
        rd(2'd2, v); chk("R4 R7 status bits", v & 32'h6, 32'h6);
        rd(2'd1, v); chk("R4 mode unchanged", v, 32'h000A_1014);
        rd(2'd2, v); chk("R10 status cleared", v, 32'h0);

        // R3 wrong key and missing restart bit
        idle(40);
        wr(2'd0, 32'h3300_0001);
        wr(2'd0, {KEY, 24'h000000});
        rd(2'd3, v); chk("R3 no reload without key", {31'b0, v < 32'd19}, 32'd1);
        rd(2'd2, v); chk("R3 no blocked flag", v & 32'h4, 32'h0);

        // R2 R8 underflow raises fault only
        idle(200);
        chk("R8 fault_irq on underflow", {31'b0, fault_irq}, 32'd1);
        chk("R8 rst_req disabled", {31'b0, rst_req}, 32'd0);
        rd(2'd2, v); chk("R2 underflow flag", v & 32'h1, 32'h1);

        // R2 no slow pulses, no counting
        slow_sel = 2; idle(2);
        rd(2'd3, a); idle(30); rd(2'd3, b);
        chk("R2 frozen without slow pulses", b, a);
        slow_sel = 0;

        // R9 idle halt
        wr(2'd1, 32'h000A_5014);
        idle(8); idle_i = 1'b1; idle(2);
        rd(2'd3, a); idle(30); rd(2'd3, b);
        chk("R9 idle halt freezes", b, a);
        idle_i = 1'b0; idle(20); rd(2'd3, v);
        chk("R9 counts after idle", {31'b0, v != b}, 32'd1);

        // R9 debug halt; idle ignored when its bit is clear
        wr(2'd1, 32'h000A_9014);
        idle(8); dbg_i = 1'b1; idle_i = 1'b1; idle(2);
        rd(2'd3, a); idle(30); rd(2'd3, b);
        chk("R9 debug halt freezes", b, a);
        dbg_i = 1'b0; idle(20); rd(2'd3, v);
        chk("R9 idle ignored without bit", {31'b0, v != b}, 32'd1);
        idle_i = 1'b0;

        // R5 disable freezes fields and count
        wr(2'd1, 32'h8000_2007);
        idle(8);
        rd(2'd1, v); chk("R5 fields kept on disabling write", v, 32'h800A_2014);
        rd(2'd3, a); idle(30); rd(2'd3, b);
        chk("R5 count frozen while disabled", b, a);
        wr(2'd1, 32'h0000_2007);
        idle(8);
        rd(2'd1, v); chk("R5 fields kept while disabled", v, 32'h000A_2014);
        wr(2'd1, 32'h0003_2007);
        rd(2'd3, v); chk("R6 mode write reloads", {31'b0, v >= 32'd6 && v <= 32'd7}, 32'd1);
        rd(2'd1, v); chk("R5 fields accepted when enabled", v, 32'h0003_2007);

        // R8 reset request on underflow
        idle(100);
        chk("R8 rst_req on underflow", {31'b0, rst_req}, 32'd1);
        chk("R8 fault_irq disabled", {31'b0, fault_irq}, 32'd0);
        rd(2'd2, v);
        chk("R10 rst_req drops after read", {31'b0, rst_req}, 32'd0);

        // R7 restart inside window is clean
        for (int i = 0; i < 60; i++) begin
            rd(2'd3, v);
            if (v <= 32'd3 && v >= 32'd1) break;
        end
        wr(2'd0, {KEY, 24'h000001});
        rd(2'd2, v); chk("R7 no window error", v & 32'h2, 32'h0);

        idle(20);
        done = 1'b1;
        finish_run();
    end
endmodule